// File: doc/BRIEF.md
# Multi-Granularity Preemption Sequencer

This block runs the context switch of a small execution unit when a preemption request arrives. Two depths of interruption are supported, picked per request by a mode input. In the coarse (thread-boundary) mode the sequencer closes the work-issue gate and waits until every item already in flight has retired. Only then does it store a short context: the program counter followed by a few state words. In the fine (instruction-boundary) mode it raises a halt line that freezes each thread before its next instruction. Threads do not have to finish, so it waits only for the halt acknowledgement. It then stores the program counter, the whole register file and the local cache contents.

Saved words go to external memory through a valid/ready write channel, one word after another from a base address, and backpressure is honoured. A completed switch is marked by a single-cycle done pulse, together with a measured request-to-done latency. A later restore command reads the same words back in the same order, writes the state words into the unit, returns the saved program counter and reopens issue. Coarse mode suits graphics-style work; fine mode suits long compute kernels.

Top module: `preempt_seq`

## Requirements
- R1: While the preemption request is high, and in every cycle the sequencer is not idle, `lane_valid_o` and `wi_ready_o` are 0, combinationally from the cycle the request is first seen.
- R2: In coarse mode (`gran_fine_i`=0 at acceptance) no memory write occurs until `inflight_i` is 0, and `halt_o` stays 0 throughout.
- R3: In fine mode (`gran_fine_i`=1 at acceptance) `halt_o` is 1 from the cycle after acceptance until the sequencer leaves the parked state. Saving starts once `halted_i` is 1, regardless of `inflight_i`, and no memory write occurs before that.
- R4: Saved word k goes to address base+k. Word 0 is `pc_i` and word k≥1 is state-port address k−1, where state-port addresses 0..RF_WORDS−1 are the register file and the next CACHE_WORDS addresses are the cache. The state read port returns data one cycle after `st_rd_en_o`.
- R5: `gran_fine_i` and `base_addr_i` are sampled when a request is accepted. Coarse mode writes exactly 1+CTX_SMALL words and fine mode exactly 1+RF_WORDS+CACHE_WORDS words; nothing is written past the last word.
- R6: While `mem_wvalid_o` is 1 and `mem_wready_i` is 0, the next cycle keeps `mem_wvalid_o` high with unchanged address and data.
- R7: `done_o` is high for exactly one cycle after the last word is accepted. Issue then stays closed until the request is low, and reopens the cycle after that.
- R8: At the done pulse `latency_o` equals the number of clock edges from the accepting edge to the edge that raises `done_o`.
- R9: A restore command, accepted in the idle state with no request, reads words base+0 upward, as many as the last save wrote. Word 0 goes to `resume_pc_o`; word k≥1 goes out on the state write port at address k−1. Then `resume_valid_o` pulses for one cycle, and issue is open in that cycle.
- R10: A preemption request that arrives during a restore, even for one cycle, is held. A new switch starts right after the restore, and no work item is issued in between.
- R11: After reset the sequencer is idle and issue passes through. `done_o`, `halt_o`, `mem_wvalid_o`, `resume_valid_o` and `latency_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gran_fine_i | input | 1 | Mode for the next request: 1 instruction boundary, 0 thread boundary |
| preempt_req_i | input | 1 | Preemption request (level) |
| restore_req_i | input | 1 | Restore command |
| base_addr_i | input | AW | Memory base address for the saved context |
| pc_i | input | DW | Current program counter of the unit |
| wi_valid_i | input | 1 | Work item offered by the scheduler |
| wi_ready_o | output | 1 | Work item taken |
| lane_valid_o | output | 1 | Work item forwarded to the lanes |
| lane_ready_i | input | 1 | Lanes can take a work item |
| inflight_i | input | CNT_W | Number of issued items not yet retired |
| halt_o | output | 1 | Freeze threads before their next instruction |
| halted_i | input | 1 | All threads frozen |
| st_rd_en_o | output | 1 | State read strobe |
| st_rd_addr_o | output | SAW | State read address |
| st_rd_data_i | input | DW | State read data, one cycle after the strobe |
| st_wr_en_o | output | 1 | State write strobe during restore |
| st_wr_addr_o | output | SAW | State write address |
| st_wr_data_o | output | DW | State write data |
| mem_wvalid_o | output | 1 | Memory write valid |
| mem_wready_i | input | 1 | Memory write ready |
| mem_waddr_o | output | AW | Memory write address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rreq_o | output | 1 | Memory read request valid |
| mem_rready_i | input | 1 | Memory read request accepted |
| mem_raddr_o | output | AW | Memory read address |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DW | Memory read data |
| done_o | output | 1 | Switch complete (one-cycle pulse) |
| latency_o | output | LAT_W | Request-to-done latency in cycles |
| resume_valid_o | output | 1 | Restore complete (one-cycle pulse) |
| resume_pc_o | output | DW | Program counter restored from memory |

## Verification
The bench builds the sequencer with DW=16, AW=12, RF_WORDS=6, CACHE_WORDS=4, CTX_SMALL=3, CNT_W=4 and LAT_W=12. A fine save is then eleven words and a coarse save four. Every saved word can be compared against a computed pattern, and the word just past each context can be checked as untouched. The short contexts also make it easy to land a one-cycle request in the middle of a restore, and to push every word through a stalling write channel and a stalling read-request channel. The latency can be checked against cycles the bench counts itself.

// File: rtl/preempt_seq.sv
module preempt_seq #(
  parameter int DW          = 32,
  parameter int AW          = 16,
  parameter int RF_WORDS    = 16,
  parameter int CACHE_WORDS = 8,
  parameter int CTX_SMALL   = 4,
  parameter int CNT_W       = 8,
  parameter int LAT_W       = 16,
  parameter int SAW         = $clog2(RF_WORDS + CACHE_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gran_fine_i,
  input  logic             preempt_req_i,
  input  logic             restore_req_i,
  input  logic [AW-1:0]    base_addr_i,
  input  logic [DW-1:0]    pc_i,
  input  logic             wi_valid_i,
  output logic             wi_ready_o,
  output logic             lane_valid_o,
  input  logic             lane_ready_i,
  input  logic [CNT_W-1:0] inflight_i,
  output logic             halt_o,
  input  logic             halted_i,
  output logic             st_rd_en_o,
  output logic [SAW-1:0]   st_rd_addr_o,
  input  logic [DW-1:0]    st_rd_data_i,
  output logic             st_wr_en_o,
  output logic [SAW-1:0]   st_wr_addr_o,
  output logic [DW-1:0]    st_wr_data_o,
  output logic             mem_wvalid_o,
  input  logic             mem_wready_i,
  output logic [AW-1:0]    mem_waddr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             mem_rreq_o,
  input  logic             mem_rready_i,
  output logic [AW-1:0]    mem_raddr_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             done_o,
  output logic [LAT_W-1:0] latency_o,
  output logic             resume_valid_o,
  output logic [DW-1:0]    resume_pc_o
);
  localparam int N_FULL = RF_WORDS + CACHE_WORDS;
  localparam int IW     = $clog2(N_FULL + 1) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_DRAIN, S_HALT, S_SAVE, S_DONE, S_PARK, S_REST
  } state_t;

  localparam logic [1:0] P_FETCH = 2'd0;
  localparam logic [1:0] P_CAP   = 2'd1;
  localparam logic [1:0] P_WRITE = 2'd2;

  state_t            st_q;
  logic              fine_q, pend_q, rsm_q;
  logic [1:0]        ph_q;
  logic [IW-1:0]     idx_q;
  logic [DW-1:0]     buf_q, rpc_q;
  logic [AW-1:0]     base_q;
  logic [LAT_W-1:0]  lat_cnt_q, lat_q;

  logic              open_w, at_last;
  logic [IW-1:0]     last_idx, idx_m1;

  assign last_idx = fine_q ? IW'(N_FULL) : IW'(CTX_SMALL);
  assign at_last  = (idx_q == last_idx);
  assign idx_m1   = idx_q - 1'b1;

  assign open_w       = (st_q == S_IDLE) && !preempt_req_i && !pend_q;
  assign lane_valid_o = wi_valid_i && open_w;
  assign wi_ready_o   = lane_ready_i && open_w;

  assign halt_o = fine_q && (st_q == S_HALT || st_q == S_SAVE ||
                             st_q == S_DONE || st_q == S_PARK);

  assign st_rd_en_o   = (st_q == S_SAVE) && (ph_q == P_FETCH) && (idx_q != '0);
  assign st_rd_addr_o = idx_m1[SAW-1:0];

  assign mem_wvalid_o = (st_q == S_SAVE) && (ph_q == P_WRITE);
  assign mem_waddr_o  = base_q + AW'(idx_q);
  assign mem_wdata_o  = buf_q;

  assign mem_rreq_o   = (st_q == S_REST) && (ph_q == P_FETCH);
  assign mem_raddr_o  = base_q + AW'(idx_q);

  assign st_wr_en_o   = (st_q == S_REST) && (ph_q == P_CAP) && mem_rvalid_i && (idx_q != '0);
  assign st_wr_addr_o = idx_m1[SAW-1:0];
  assign st_wr_data_o = mem_rdata_i;

  assign done_o         = (st_q == S_DONE);
  assign latency_o      = lat_q;
  assign resume_valid_o = rsm_q;
  assign resume_pc_o    = rpc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      fine_q    <= 1'b0;
      pend_q    <= 1'b0;
      rsm_q     <= 1'b0;
      ph_q      <= P_FETCH;
      idx_q     <= '0;
      buf_q     <= '0;
      rpc_q     <= '0;
      base_q    <= '0;
      lat_cnt_q <= '0;
      lat_q     <= '0;
    end else begin
      rsm_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (preempt_req_i || pend_q) begin
            fine_q    <= gran_fine_i;
            base_q    <= base_addr_i;
            pend_q    <= 1'b0;
            lat_cnt_q <= '0;
            idx_q     <= '0;
            ph_q      <= P_FETCH;
            st_q      <= gran_fine_i ? S_HALT : S_DRAIN;
          end else if (restore_req_i) begin
            idx_q <= '0;
            ph_q  <= P_FETCH;
            st_q  <= S_REST;
          end
        end
        S_DRAIN: begin
          lat_cnt_q <= lat_cnt_q + 1'b1;
          if (inflight_i == '0) st_q <= S_SAVE;
        end
        S_HALT: begin
          lat_cnt_q <= lat_cnt_q + 1'b1;
          if (halted_i) st_q <= S_SAVE;
        end
        S_SAVE: begin
          lat_cnt_q <= lat_cnt_q + 1'b1;
          case (ph_q)
            P_FETCH: ph_q <= P_CAP;
            P_CAP: begin
              buf_q <= (idx_q == '0) ? pc_i : st_rd_data_i;
              ph_q  <= P_WRITE;
            end
            default: begin
              if (mem_wready_i) begin
                if (at_last) begin
                  st_q  <= S_DONE;
                  lat_q <= lat_cnt_q + 1'b1;
                end else begin
                  idx_q <= idx_q + 1'b1;
                  ph_q  <= P_FETCH;
                end
              end
            end
          endcase
        end
        S_DONE: st_q <= S_PARK;
        S_PARK: if (!preempt_req_i) st_q <= S_IDLE;
        S_REST: begin
          if (preempt_req_i) pend_q <= 1'b1;
          if (ph_q == P_FETCH) begin
            if (mem_rready_i) ph_q <= P_CAP;
          end else if (mem_rvalid_i) begin
            if (idx_q == '0) rpc_q <= mem_rdata_i;
            if (at_last) begin
              st_q  <= S_IDLE;
              rsm_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              ph_q  <= P_FETCH;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/preempt_seq_chk.sv
module preempt_seq_chk #(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             preempt_req_i,
  input logic             lane_valid_o,
  input logic             wi_ready_o,
  input logic             halt_o,
  input logic [CNT_W-1:0] inflight_i,
  input logic             mem_wvalid_o,
  input logic             mem_wready_i,
  input logic [AW-1:0]    mem_waddr_o,
  input logic [DW-1:0]    mem_wdata_o,
  input logic             mem_rreq_o,
  input logic             st_wr_en_o,
  input logic             done_o,
  input logic             resume_valid_o
);
  AST_GATE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req_i |-> (!lane_valid_o && !wi_ready_o)); // R1

  AST_DRAIN_BEFORE_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid_o && !halt_o) |-> (inflight_i == '0)); // R2

  AST_HALT_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !lane_valid_o); // R3

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid_o && !mem_wready_i) |=>
      (mem_wvalid_o && $stable(mem_waddr_o) && $stable(mem_wdata_o))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid_o |=> !resume_valid_o); // R9

  AST_ONE_MEM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wvalid_o, mem_rreq_o, st_wr_en_o})); // R9
endmodule

bind preempt_seq preempt_seq_chk #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .preempt_req_i  (preempt_req_i),
  .lane_valid_o   (lane_valid_o),
  .wi_ready_o     (wi_ready_o),
  .halt_o         (halt_o),
  .inflight_i     (inflight_i),
  .mem_wvalid_o   (mem_wvalid_o),
  .mem_wready_i   (mem_wready_i),
  .mem_waddr_o    (mem_waddr_o),
  .mem_wdata_o    (mem_wdata_o),
  .mem_rreq_o     (mem_rreq_o),
  .st_wr_en_o     (st_wr_en_o),
  .done_o         (done_o),
  .resume_valid_o (resume_valid_o)
);

// File: tb/preempt_seq_tb_top.sv
module preempt_seq_tb_top;
  localparam int DW = 16, AW = 12, RFW = 6, CW = 4, CS = 3, CNT = 4, LW = 12;
  localparam int NF = RFW + CW;
  localparam int SAW = $clog2(NF);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic gran = 1'b0, preq = 1'b0, rreq_cmd = 1'b0;
  logic [AW-1:0] base = '0;
  logic [DW-1:0] pc = '0;
  logic wi_valid = 1'b1, wi_ready, lane_valid, lane_ready = 1'b1;
  logic [CNT-1:0] inflight = '0;
  logic halt, halted = 1'b0;
  logic st_rd_en, st_wr_en;
  logic [SAW-1:0] st_rd_addr, st_wr_addr;
  logic [DW-1:0] st_rdata = '0, st_wr_data;
  logic mem_wvalid, mem_wready, mem_rreq, mem_rready;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic mem_rvalid = 1'b0;
  logic done, resume_valid;
  logic [LW-1:0] latency;
  logic [DW-1:0] resume_pc;

  logic [DW-1:0] st_mem [NF];
  logic [DW-1:0] ext [256];
  logic st_load = 1'b0, st_clr = 1'b0, ext_clr = 1'b0, bp = 1'b0;
  int seed = 0;
  int cyc = 0;
  int compared = 0, mismatched = 0;

  assign mem_wready = bp ? (cyc % 3 != 0) : 1'b1;
  assign mem_rready = bp ? (cyc % 2 == 0) : 1'b1;

  preempt_seq #(.DW(DW), .AW(AW), .RF_WORDS(RFW), .CACHE_WORDS(CW), .CTX_SMALL(CS),
                .CNT_W(CNT), .LAT_W(LW), .SAW(SAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .gran_fine_i(gran), .preempt_req_i(preq),
    .restore_req_i(rreq_cmd), .base_addr_i(base), .pc_i(pc),
    .wi_valid_i(wi_valid), .wi_ready_o(wi_ready), .lane_valid_o(lane_valid),
    .lane_ready_i(lane_ready), .inflight_i(inflight), .halt_o(halt), .halted_i(halted),
    .st_rd_en_o(st_rd_en), .st_rd_addr_o(st_rd_addr), .st_rd_data_i(st_rdata),
    .st_wr_en_o(st_wr_en), .st_wr_addr_o(st_wr_addr), .st_wr_data_o(st_wr_data),
    .mem_wvalid_o(mem_wvalid), .mem_wready_i(mem_wready), .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata), .mem_rreq_o(mem_rreq), .mem_rready_i(mem_rready),
    .mem_raddr_o(mem_raddr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .latency_o(latency), .resume_valid_o(resume_valid),
    .resume_pc_o(resume_pc));

  function automatic logic [DW-1:0] pat(input int s, input int i);
    return DW'(s * 257 + i * 55 + 5);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (st_load) for (int i = 0; i < NF; i++) st_mem[i] <= pat(seed, i);
    else if (st_clr) for (int i = 0; i < NF; i++) st_mem[i] <= '0;
    else if (st_wr_en) st_mem[st_wr_addr] <= st_wr_data;
    if (st_rd_en) st_rdata <= st_mem[st_rd_addr];
    if (ext_clr) for (int i = 0; i < 256; i++) ext[i] <= 16'hDEAD;
    else if (mem_wvalid && mem_wready) ext[mem_waddr[7:0]] <= mem_wdata;
    mem_rvalid <= mem_rreq && mem_rready;
    mem_rdata  <= ext[mem_raddr[7:0]];
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // R6: a stalled write keeps its address and data
  logic hold_pend = 1'b0;
  logic [AW-1:0] hold_a;
  logic [DW-1:0] hold_d;
  always @(negedge clk) begin
    if (hold_pend)
      chk(mem_wvalid && mem_waddr == hold_a && mem_wdata == hold_d,
          "R6 write held under backpressure", int'(mem_waddr), int'(hold_a));
    hold_pend = rst_n && mem_wvalid && !mem_wready;
    hold_a = mem_waddr;
    hold_d = mem_wdata;
  end

  task automatic load_state(input int s);
    seed = s; st_load = 1'b1; ext_clr = 1'b1;
    @(negedge clk);
    st_load = 1'b0; ext_clr = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lane_valid == 1'b1 && wi_ready == 1'b1, "R11 issue open after reset", lane_valid, 1);
    chk(!done && !halt && !mem_wvalid && !resume_valid, "R11 outputs idle",
        {done, halt, mem_wvalid, resume_valid}, 0);
    chk(latency == '0, "R11 latency reset", latency, 0);
  endtask

  task automatic t_coarse;
    int n = 0, early = 0, halts = 0, leaks = 0;
    load_state(3);
    inflight = 4'd3; gran = 1'b0; base = 12'h020; pc = 16'h1A2B; bp = 1'b1;
    preq = 1'b1;
    #1 chk(!lane_valid && !wi_ready, "R1 gate closes with request", lane_valid, 0);
    while (n < 500) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 2) inflight = 4'd2;
      if (n == 4) inflight = 4'd1;
      if (n == 6) inflight = 4'd0;
      if (inflight != 0 && mem_wvalid) early++;
      if (halt) halts++;
      if (lane_valid) leaks++;
      if (done) break;
    end
    chk(done, "R7 coarse done reached", done, 1);
    chk(early == 0, "R2 no write before drain", early, 0);
    chk(halts == 0, "R2 halt low in coarse mode", halts, 0);
    chk(leaks == 0, "R1 no issue during switch", leaks, 0);
    chk(int'(latency) == n - 1, "R8 coarse latency", latency, n - 1);
    for (int k = 0; k <= CS; k++)
      chk(ext[8'h20 + k] == (k == 0 ? pc : pat(3, k - 1)), "R4 coarse word",
          ext[8'h20 + k], (k == 0 ? pc : pat(3, k - 1)));
    chk(ext[8'h20 + CS + 1] == 16'hDEAD, "R5 coarse writes only small context",
        ext[8'h20 + CS + 1], 16'hDEAD);
    @(negedge clk);
    chk(!done, "R7 done is one cycle", done, 0);
    chk(!lane_valid, "R7 issue blocked while request high", lane_valid, 0);
    preq = 1'b0;
    @(negedge clk);
    chk(lane_valid, "R7 issue reopens after request drops", lane_valid, 1);
    bp = 1'b0;
  endtask

  task automatic t_fine;
    int n = 0, early = 0;
    load_state(5);
    inflight = 4'd5; halted = 1'b0; gran = 1'b1; base = 12'h040; pc = 16'h3C4D;
    preq = 1'b1;
    @(negedge clk); n++;
    chk(halt, "R3 halt raised after acceptance", halt, 1);
    repeat (4) begin
      @(negedge clk); n++;
      if (mem_wvalid) early++;
    end
    chk(early == 0, "R3 no write before halted", early, 0);
    halted = 1'b1;
    while (n < 500) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (done) break;
    end
    chk(done, "R3 fine save completes with items in flight", done, 1);
    chk(int'(latency) == n - 1, "R8 fine latency", latency, n - 1);
    for (int k = 0; k <= NF; k++)
      chk(ext[8'h40 + k] == (k == 0 ? pc : pat(5, k - 1)), "R4 fine word",
          ext[8'h40 + k], (k == 0 ? pc : pat(5, k - 1)));
    chk(ext[8'h40 + NF + 1] == 16'hDEAD, "R5 fine stops after full context",
        ext[8'h40 + NF + 1], 16'hDEAD);
    @(negedge clk);
    chk(halt && !lane_valid, "R3 halt held while parked", halt, 1);
    preq = 1'b0;
    @(negedge clk);
    chk(!halt && lane_valid, "R3 halt released and issue open", {halt, lane_valid}, 1);
    halted = 1'b0; inflight = 4'd0;
  endtask

  task automatic t_restore;
    int n = 0, leaks = 0;
    st_clr = 1'b1; bp = 1'b1;
    @(negedge clk);
    st_clr = 1'b0; rreq_cmd = 1'b1;
    @(negedge clk);
    rreq_cmd = 1'b0;
    while (n < 500 && !resume_valid) begin
      if (lane_valid) leaks++;
      @(negedge clk); n++;
    end
    chk(resume_valid, "R9 resume pulse", resume_valid, 1);
    chk(leaks == 0, "R1 no issue during restore", leaks, 0);
    chk(resume_pc == 16'h3C4D, "R9 restored pc", resume_pc, 16'h3C4D);
    chk(lane_valid, "R9 issue open at resume", lane_valid, 1);
    for (int i = 0; i < NF; i++)
      chk(st_mem[i] == pat(5, i), "R9 restored state word", st_mem[i], pat(5, i));
    @(negedge clk);
    chk(!resume_valid, "R9 resume is one cycle", resume_valid, 0);
    bp = 1'b0;
  endtask

  task automatic t_held;
    int n = 0, leaks = 0, halts = 0;
    gran = 1'b0; base = 12'h060; pc = 16'h5E6F; inflight = 4'd0;
    rreq_cmd = 1'b1;
    @(negedge clk);
    rreq_cmd = 1'b0;
    repeat (3) @(negedge clk);
    preq = 1'b1;
    @(negedge clk);
    preq = 1'b0;
    while (n < 500 && !resume_valid) begin
      if (lane_valid) leaks++;
      @(negedge clk); n++;
    end
    chk(resume_valid && !lane_valid, "R10 issue stays closed at resume", lane_valid, 0);
    n = 0;
    while (n < 500 && !done) begin
      if (lane_valid) leaks++;
      if (halt) halts++;
      @(negedge clk); n++;
    end
    chk(done, "R10 held request runs a switch", done, 1);
    chk(leaks == 0, "R10 no issue between restore and switch", leaks, 0);
    chk(halts == 0, "R5 mode sampled at acceptance", halts, 0);
    chk(ext[8'h60] == 16'h5E6F, "R10 held switch pc word", ext[8'h60], 16'h5E6F);
    for (int k = 1; k <= CS; k++)
      chk(ext[8'h60 + k] == pat(5, k - 1), "R10 held switch state word",
          ext[8'h60 + k], pat(5, k - 1));
    repeat (2) @(negedge clk);
    chk(lane_valid, "R7 issue reopens after held switch", lane_valid, 1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_coarse();
    t_fine();
    t_restore();
    t_held();
    summary();
    $finish;
  end
endmodule